// File: doc/BRIEF.md
# Divider Configuration Port with Serial and Parallel Loading

This block holds the settings of a frequency synthesizer's divider chain: a 9-bit feedback divide value, two 3-bit output divide codes (one per output bank) and a 2-bit test selector. It accepts settings in two ways. The first is a parallel word, which follows the pins while a parallel strobe is low and freezes when that strobe goes high. The second is a three-wire serial path: data, a serial clock and a load strobe. The block shows the divider logic the settings in force at each moment. It also raises a flag when the feedback value lies outside the range in which the loop can lock.

The test selector drives a single debug pin. That pin can be held low, show the last stage of the serial shift register so that several parts can be chained, show the feedback divider output, or show the bank-A output clock. A master-reset input silences the debug pin and leaves the stored settings as they are.

All control pins are sampled on the rising edge of a system clock. A serial clock edge is therefore seen one system clock after it arrives, and a serial-strobe edge is handled the same way. The serial clock must stay high for at least one system clock and low for at least one system clock. A serial frame has 17 bits and is sent test bits first and M0 last. The block has no data stream, so every pin is a plain level.

Top module: `divcfg_ctrl`

## Requirements
- R1: While `par_latch` is 0, `m_eff`, `na_eff` and `nb_eff` equal `par_m`, `par_na` and `par_nb` in the same cycle, and `test_out` is 0.
- R2: When `par_latch` is seen high, the parallel value sampled at the last clock edge before that point stays in force. Later changes on the parallel inputs have no effect while `ser_strobe` stays 0.
- R3: The 17-bit shift register moves one place toward its top bit on each sampled rising edge of `ser_clk`, taking `ser_data` into bit 0. It does this only while `par_latch` is 1. The frame layout is bit16=T1, bit15=T0, bits 14:12 = NB, bits 11:9 = NA, bits 8:0 = M, so the first bit shifted in lands in bit16.
- R4: A sampled rising edge of `ser_strobe` (with `par_latch` 1) copies the shift register into the settings in force. The new values appear one cycle after the edge is sampled.
- R5: While `ser_strobe` stays 1, each sampled rising edge of `ser_clk` writes the newly shifted register into the settings in force.
- R6: After `ser_strobe` falls, the settings stay fixed while more serial bits are shifted in.
- R7: A serial load replaces a parallel value that was latched earlier. When `par_latch` returns to 0, the parallel inputs are in force again.
- R8: With `par_latch` 1, `test_out` follows the test selector {T1,T0}: 00 gives 0; 01 gives shift-register bit 16; 10 gives `mdiv_in`; 11 gives `fouta_in`.
- R9: While `hold_rst` is 1, `test_out` is 0, and the settings in force do not change.
- R10: `m_bad` is 1 exactly when `m_eff` is below `M_MIN` (23) or above `M_MAX` (30).
- R11: After reset, the settings in force come from the parallel inputs, the test selector is 00 and the shift register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control pin |
| rst_n | input | 1 | Synchronous reset, active low |
| par_latch | input | 1 | 0: parallel word is passed through; 1: held, and serial loading is enabled |
| par_m | input | 9 | Parallel feedback divide value |
| par_na | input | 3 | Parallel bank-A divide code |
| par_nb | input | 3 | Parallel bank-B divide code |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial load strobe: transfers on its rise and is transparent while high |
| hold_rst | input | 1 | Master reset of the outputs; holds the debug pin low |
| mdiv_in | input | 1 | Feedback divider output, for the debug pin |
| fouta_in | input | 1 | Bank-A output clock, for the debug pin |
| m_eff | output | 9 | Feedback divide value in force |
| na_eff | output | 3 | Bank-A code in force |
| nb_eff | output | 3 | Bank-B code in force |
| test_out | output | 1 | Debug pin |
| m_bad | output | 1 | Feedback value outside the lock range |

## Verification
The bench attacks the points where the two load paths meet. It changes the parallel pins after they are latched, which a design with a missing latch would pass through. It shifts a frame with the strobe low, which a design lacking a hold register would show at once. It loads a serial frame over a latched parallel value, which a design that gave priority to the parallel path would ignore. It toggles the serial clock while the parallel strobe is low, which a design with loose gating would shift. It pulses the serial clock with the strobe held high and then dropped, which separates a transparent load from one that acts only on an edge. It reads one extra shifted bit on the chain tap, which exposes a reversed frame or the wrong tap stage.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 3;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 2 * N_W + M_W;

  // packed so that the struct bit layout equals the serial frame layout
  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] nb;
    logic [N_W-1:0] na;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [1:0] {
    TS_LOW   = 2'b00,
    TS_CHAIN = 2'b01,
    TS_FDBK  = 2'b10,
    TS_BANKA = 2'b11
  } tsel_e;
endpackage

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  // reset to ones: a level already high at release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int FW = divcfg_pkg::FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [FW-1:0] sr,
  output logic [FW-1:0] sr_nxt
);
  always_comb begin
    sr_nxt = shift_en ? {sr[FW-2:0], din} : sr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end
endmodule

// File: rtl/divcfg_test_mux.sv
module divcfg_test_mux
  import divcfg_pkg::*;
(
  input  logic           force_low,
  input  logic [T_W-1:0] tsel,
  input  logic           chain_bit,
  input  logic           fdbk,
  input  logic           banka,
  output logic           test_out
);
  always_comb begin
    test_out = 1'b0;
    if (!force_low) begin
      case (tsel_e'(tsel))
        TS_LOW:   test_out = 1'b0;
        TS_CHAIN: test_out = chain_bit;
        TS_FDBK:  test_out = fdbk;
        TS_BANKA: test_out = banka;
        default:  test_out = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 23,
  parameter int M_MAX = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_latch,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_na,
  input  logic [N_W-1:0] par_nb,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_strobe,
  input  logic           hold_rst,
  input  logic           mdiv_in,
  input  logic           fouta_in,
  output logic [M_W-1:0] m_eff,
  output logic [N_W-1:0] na_eff,
  output logic [N_W-1:0] nb_eff,
  output logic           test_out,
  output logic           m_bad
);
  logic [1:0]         rise;
  logic               sclk_rise;
  logic               stb_rise;
  logic [FRAME_W-1:0] sr;
  logic [FRAME_W-1:0] sr_nxt;
  cfg_t               cfg_q;

  divcfg_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({ser_strobe, ser_clk}),
    .rise  (rise)
  );
  assign sclk_rise = rise[0];
  assign stb_rise  = rise[1];

  divcfg_shift #(.FW(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (par_latch & sclk_rise),
    .din      (ser_data),
    .sr       (sr),
    .sr_nxt   (sr_nxt)
  );

  // holding register: tracks parallel pins while transparent,
  // takes the shift register on a serial load or while the strobe is high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.m    <= par_m;
      cfg_q.na   <= par_na;
      cfg_q.nb   <= par_nb;
      cfg_q.tsel <= '0;
    end else if (!par_latch) begin
      cfg_q.m    <= par_m;
      cfg_q.na   <= par_na;
      cfg_q.nb   <= par_nb;
    end else if (ser_strobe && (stb_rise || sclk_rise)) begin
      cfg_q <= cfg_t'(sr_nxt);
    end
  end

  always_comb begin
    if (par_latch) begin
      m_eff  = cfg_q.m;
      na_eff = cfg_q.na;
      nb_eff = cfg_q.nb;
    end else begin
      m_eff  = par_m;
      na_eff = par_na;
      nb_eff = par_nb;
    end
  end

  assign m_bad = (int'(m_eff) < M_MIN) || (int'(m_eff) > M_MAX);

  divcfg_test_mux u_tmux (
    .force_low (~par_latch | hold_rst),
    .tsel      (cfg_q.tsel),
    .chain_bit (sr[FRAME_W-1]),
    .fdbk      (mdiv_in),
    .banka     (fouta_in),
    .test_out  (test_out)
  );
endmodule

// File: rtl/divcfg_ctrl_chk.sv
module divcfg_ctrl_chk
  import divcfg_pkg::*;
#(
  parameter int M_MIN = 23,
  parameter int M_MAX = 30
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_latch,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_na,
  input logic [N_W-1:0] par_nb,
  input logic           ser_strobe,
  input logic           hold_rst,
  input logic [M_W-1:0] m_eff,
  input logic [N_W-1:0] na_eff,
  input logic [N_W-1:0] nb_eff,
  input logic           test_out,
  input logic           m_bad
);
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !par_latch |-> (m_eff == par_m && na_eff == par_na && nb_eff == par_nb && !test_out)); // R1

  AST_HOLD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (par_latch && $past(par_latch) && !ser_strobe && !$past(ser_strobe) && $past(rst_n))
    |-> ($stable(m_eff) && $stable(na_eff) && $stable(nb_eff))); // R2

  AST_MR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |-> !test_out); // R9

  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !par_latch |-> (m_bad == ((int'(par_m) < M_MIN) || (int'(par_m) > M_MAX)))); // R10
endmodule

bind divcfg_ctrl divcfg_ctrl_chk #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (.*);

// File: tb/divcfg_ctrl_test.sv
module divcfg_ctrl_test;
  localparam int PERIOD = 10;
  localparam int FW = 17;

  logic       clk = 1'b0;
  logic       rst_n, par_latch, ser_clk, ser_data, ser_strobe, hold_rst, mdiv_in, fouta_in;
  logic [8:0] par_m;
  logic [2:0] par_na, par_nb;
  logic [8:0] m_eff;
  logic [2:0] na_eff, nb_eff;
  logic       test_out, m_bad;

  int nvec = 0;
  int nerr = 0;
  logic [FW-1:0] bsr = '0;  // bench model of the shift register

  always #(PERIOD/2) clk = ~clk;

  divcfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .par_latch(par_latch), .par_m(par_m),
    .par_na(par_na), .par_nb(par_nb), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .hold_rst(hold_rst), .mdiv_in(mdiv_in),
    .fouta_in(fouta_in), .m_eff(m_eff), .na_eff(na_eff), .nb_eff(nb_eff),
    .test_out(test_out), .m_bad(m_bad)
  );

  function automatic logic exp_bad(input logic [8:0] m);
    return (m < 9'd23) || (m > 9'd30);
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic chain,
                                    input logic fd, input logic fa);
    case (t)
      2'b00:   return 1'b0;
      2'b01:   return chain;
      2'b10:   return fd;
      default: return fa;
    endcase
  endfunction

  function automatic logic [FW-1:0] mk_frame(input logic [1:0] t, input logic [2:0] nb,
                                             input logic [2:0] na, input logic [8:0] m);
    return {t, nb, na, m};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_cfg(input string req, input logic [8:0] m, input logic [2:0] na,
                         input logic [2:0] nb);
    chk({req, " m"},  32'(m_eff),  32'(m));
    chk({req, " na"}, 32'(na_eff), 32'(na));
    chk({req, " nb"}, 32'(nb_eff), 32'(nb));
  endtask

  task automatic shift_bit(input logic b, input logic model_on);
    ser_data = b;
    ser_clk  = 1'b1;
    tick();
    ser_clk  = 1'b0;
    tick();
    if (model_on) bsr = {bsr[FW-2:0], b};
  endtask

  task automatic shift_frame(input logic [FW-1:0] f, input logic model_on);
    for (int i = FW - 1; i >= 0; i--) shift_bit(f[i], model_on);
  endtask

  task automatic strobe_pulse();
    ser_strobe = 1'b1;
    tick();
    ser_strobe = 1'b0;
    tick();
  endtask

  initial begin
    #(PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [8:0] hm;
    logic [2:0] hna, hnb;
    void'($urandom(32'd1234));
    rst_n = 0; par_latch = 0; par_m = 9'd25; par_na = 3'b011; par_nb = 3'b011;
    ser_clk = 0; ser_data = 0; ser_strobe = 0; hold_rst = 0; mdiv_in = 0; fouta_in = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R11 reset state
    chk_cfg("R11", 9'd25, 3'b011, 3'b011);
    chk("R11 test_out", 32'(test_out), 0);
    chk("R11 m_bad", 32'(m_bad), 0);

    // R1 pass-through with random parallel words, R10 flag
    for (int i = 0; i < 8; i++) begin
      par_m = 9'($urandom_range(0, 40)); par_na = 3'($urandom); par_nb = 3'($urandom);
      tick();
      chk_cfg("R1", par_m, par_na, par_nb);
      chk("R1 test_out", 32'(test_out), 0);
      chk("R10 flag", 32'(m_bad), 32'(exp_bad(par_m)));
    end
    par_m = 9'd23; tick(); chk("R10 low edge", 32'(m_bad), 0);
    par_m = 9'd22; tick(); chk("R10 below", 32'(m_bad), 1);
    par_m = 9'd30; tick(); chk("R10 high edge", 32'(m_bad), 0);
    par_m = 9'd31; tick(); chk("R10 above", 32'(m_bad), 1);

    // R2 parallel latch ignores later pin changes
    par_m = 9'd24; par_na = 3'd5; par_nb = 3'd6;
    tick();
    par_latch = 1;
    par_m = 9'd100; par_na = 3'd1; par_nb = 3'd2;
    tick(); tick();
    chk_cfg("R2", 9'd24, 3'd5, 3'd6);
    chk("R8 code 00", 32'(test_out), 0);

    // R6 shifting with strobe low keeps values; R4/R7 load overrides latch
    shift_frame(mk_frame(2'b01, 3'd2, 3'd4, 9'd27), 1'b1);
    chk_cfg("R6 pre-load", 9'd24, 3'd5, 3'd6);
    strobe_pulse();
    chk_cfg("R4 R7 serial load", 9'd27, 3'd4, 3'd2);
    chk("R8 code 01 chain", 32'(test_out), 32'(bsr[FW-1]));
    shift_bit(1'b0, 1'b1);
    chk("R3 frame order tap", 32'(test_out), 1);  // former bit15 = T0 = 1
    chk_cfg("R6 after extra bit", 9'd27, 3'd4, 3'd2);

    // R8 feedback tap and bank-A tap
    shift_frame(mk_frame(2'b10, 3'd1, 3'd1, 9'd40), 1'b1);
    strobe_pulse();
    chk("R10 serial 40", 32'(m_bad), 1);
    mdiv_in = 1; tick(); chk("R8 code 10 hi", 32'(test_out), 1);
    mdiv_in = 0; tick(); chk("R8 code 10 lo", 32'(test_out), 0);
    shift_frame(mk_frame(2'b11, 3'd7, 3'd0, 9'd28), 1'b1);
    strobe_pulse();
    fouta_in = 1; tick(); chk("R8 code 11 hi", 32'(test_out), 1);

    // R9 master reset silences the pin, settings intact
    hold_rst = 1; tick();
    chk("R9 test_out", 32'(test_out), 0);
    chk_cfg("R9 kept", 9'd28, 3'd0, 3'd7);
    hold_rst = 0; tick();
    chk("R9 release", 32'(test_out), 1);
    fouta_in = 0;

    // R5 transparent strobe, R6 hold after fall
    ser_strobe = 1; tick();
    for (int i = 0; i < 3; i++) begin
      shift_bit(1'($urandom), 1'b1);
      chk_cfg("R5 transparent", bsr[8:0], bsr[11:9], bsr[14:12]);
    end
    hm = bsr[8:0]; hna = bsr[11:9]; hnb = bsr[14:12];
    ser_strobe = 0; tick();
    shift_bit(1'b1, 1'b1);
    chk_cfg("R6 held", hm, hna, hnb);

    // R7 revert to parallel; R3 no shift while par_latch low
    par_latch = 0; par_m = 9'd26; par_na = 3'd2; par_nb = 3'd3;
    tick();
    chk_cfg("R7 revert", 9'd26, 3'd2, 3'd3);
    shift_frame(mk_frame(2'b00, 3'd0, 3'd0, 9'd0), 1'b0);
    par_latch = 1; tick();
    strobe_pulse();
    chk_cfg("R3 gated shift", bsr[8:0], bsr[11:9], bsr[14:12]);

    // random serial frames
    for (int i = 0; i < 24; i++) begin
      logic [FW-1:0] f;
      f = FW'($urandom);
      f[8:0] = 9'($urandom_range(15, 38));
      shift_frame(f, 1'b1);
      strobe_pulse();
      chk_cfg("R4 random", f[8:0], f[11:9], f[14:12]);
      chk("R10 random", 32'(m_bad), 32'(exp_bad(f[8:0])));
      mdiv_in = 1'($urandom); fouta_in = 1'($urandom);
      tick();
      chk("R8 random", 32'(test_out), 32'(exp_test(f[16:15], bsr[FW-1], mdiv_in, fouta_in)));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule